// File: doc/BRIEF.md
# Glitchless Redundant Clock Switchover

This block picks one of two unrelated input clocks and copies the picked clock onto sixteen output pairs. Each pair has a true and a complement output. When the select input changes, the block runs a handshake across the two clock domains. First the old clock is stopped on one of its falling edges. Only after that stop has been seen in the new domain is the new clock let through, starting on one of its rising edges. As a result the output never carries a pulse shorter than half a period of either source. The select input must then stay stable until the switchover has finished.

A force input lets the block recover when a source clock has died. While it is high, the deselected leg is cleared at once without any wait on its own clock. The selected leg drops its output immediately and restarts after a short synchronised hold, with no wait on the other leg. To move to the other clock in this mode, the user drops the force input, flips select, and raises force again.

Two gate inputs each park one half of the output pairs at a chosen level. A power-down input drives every output high and overrides all other inputs. All signals are plain single-ended logic.

Top module: `clksw_mux`

## Requirements
- R1: With `sel` high the outputs follow `clk1`; with `sel` low they follow `clk2`. An active pair's true output equals the selected clock.
- R2: At no time are both source clocks passed to the output together. With `fsel` low, no output high or low pulse is shorter than half the period of the faster source.
- R3: After `sel` changes, the output stops on a falling edge of the old clock. This happens no earlier than one and no later than three old-clock periods after the change, and the output then stays low.
- R4: After the stop, the output stays low for at least one and at most four periods of the new clock. It then resumes with a rising edge of the new clock.
- R5: A rising `fsel` drives the output low at once. The output then restarts from the clock chosen by `sel` within a few cycles of that clock, even if the other clock is stopped with its leg still enabled.
- R6: While `fsel` is high, the deselected clock has no effect: starting or stopping it leaves the output a clean copy of the selected clock.
- R7: Gate `g1` governs pairs 1 to 8 (output bits 0 to 7) and `g2` governs pairs 9 to 16 (bits 8 to 15). A gate low lets its pairs run. A gate high parks its pairs at once.
- R8: A parked pair shows true = `gl` and complement = not `gl`.
- R9: With `pd_n` low, every true and every complement output is high, whatever the other inputs are.
- R10: While `rst_n` is low, both clock enables are cleared, so ungated outputs sit at true = 0. After release, the selected clock is brought up through the normal low hold.
- R11: With `pd_n` high, each complement output is the inverse of its true output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk1 | input | 1 | Source clock chosen when `sel` is high |
| clk2 | input | 1 | Source clock chosen when `sel` is low |
| rst_n | input | 1 | Asynchronous active-low reset of both legs |
| sel | input | 1 | Source select: 1 picks `clk1`, 0 picks `clk2` |
| fsel | input | 1 | Force mode: bypasses the cross-domain handshake |
| g1 | input | 1 | Gate for output bits 0 to 7; high parks them |
| g2 | input | 1 | Gate for output bits 8 to 15; high parks them |
| gl | input | 1 | Park level of the true outputs |
| pd_n | input | 1 | Active-low power-down; low drives all outputs high |
| q | output | 16 | True clock outputs, bit 0 is pair 1 |
| qn | output | 16 | Complement clock outputs, bit 0 is pair 1 |

## Verification
The assertions check on every cycle that the two enables are never set together. They also check that a leg whose synchronised request has gone is already stopped, and that force mode clears the deselected leg. At the ports, they check the power-down, park-level and complement relations. The sequence timing can only be shown by the bench: where the old clock stops, how long the low gap lasts, and that no short pulse appears around each switch. The same holds for recovery from a frozen clock and for the claim that the deselected clock has no effect. The bench covers these with directed cases and seeded random switch timing, measuring pulse widths in real time.

// File: rtl/clksw_pkg.sv
`timescale 1ns/1ps
package clksw_pkg;

   // the top module exposes exactly two gate inputs
   localparam int unsigned GATE_GROUPS = 2;

   // drive of one output pair: bit 1 true side, bit 0 complement side
   function automatic logic [1:0] pair_drive(input logic ck,
                                             input logic gate,
                                             input logic park_hi,
                                             input logic pd_n);
      logic [1:0] r;
      if (!pd_n)     r = 2'b11;
      else if (gate) r = {park_hi, ~park_hi};
      else           r = {ck, ~ck};
      return r;
   endfunction

endpackage

// File: rtl/clksw_sync.sv
`timescale 1ns/1ps
module clksw_sync #(
   parameter int STAGES = 2,
   parameter int WIDTH  = 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);

   if (STAGES < 2) begin : g_bad_depth
      $error("clksw_sync needs at least two stages");
   end
   if (WIDTH < 1) begin : g_bad_width
      $error("clksw_sync needs a positive width");
   end

   logic [WIDTH-1:0] chain [STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < STAGES; i++) chain[i] <= '0;
      end else begin
         chain[0] <= d;
         for (int i = 1; i < STAGES; i++) chain[i] <= chain[i-1];
      end
   end

   assign q = chain[STAGES-1];

endmodule

// File: rtl/clksw_leg.sv
`timescale 1ns/1ps
module clksw_leg #(
   parameter int SYNC_STAGES  = 2,
   parameter bit PICK_ON_HIGH = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic sel,
   input  logic fsel,
   input  logic other_en,
   output logic en
);

   logic want_raw;

   // polarity of the select input that names this leg
   if (PICK_ON_HIGH) begin : g_pick_hi
      assign want_raw = sel;
   end else begin : g_pick_lo
      assign want_raw = ~sel;
   end

   logic [2:0] raw_in;
   logic [2:0] synced;
   logic       want_s;
   logic       other_s;
   logic       force_s;

   assign raw_in = {want_raw, other_en, fsel};

   clksw_sync #(
      .STAGES (SYNC_STAGES),
      .WIDTH  (3)
   ) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (raw_in),
      .q     (synced)
   );

   assign want_s  = synced[2];
   assign other_s = synced[1];
   assign force_s = synced[0];

   // asynchronous clear: reset, forced deselection, or fresh force entry
   logic kill;
   assign kill = ~rst_n | (fsel & ~want_raw) | (fsel & ~force_s);

   // enable moves only while this clock is low, so the gated clock
   // cannot be cut or started in its high phase
   always_ff @(negedge clk or posedge kill) begin
      if (kill) en <= 1'b0;
      else      en <= want_s & (~other_s | force_s);
   end

   // R5: forced deselection clears the leg without waiting on its clock
   p_force_drop_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (fsel && !want_raw) |-> !en);

   // R3: once the synchronised request is gone the leg is already stopped
   p_release_r3: assert property (@(posedge clk) disable iff (!rst_n || fsel)
      !want_s |-> !en);

endmodule

// File: rtl/clksw_fanout.sv
`timescale 1ns/1ps
module clksw_fanout
   import clksw_pkg::*;
#(
   parameter int NUM_PAIRS  = 16,
   parameter int NUM_GROUPS = 2
) (
   input  logic                  ck,
   input  logic [NUM_GROUPS-1:0] gate,
   input  logic                  gl,
   input  logic                  pd_n,
   output logic [NUM_PAIRS-1:0]  q,
   output logic [NUM_PAIRS-1:0]  qn
);

   localparam int PER_GROUP = NUM_PAIRS / NUM_GROUPS;

   if (NUM_GROUPS < 1 || NUM_PAIRS % NUM_GROUPS != 0) begin : g_bad_split
      $error("clksw_fanout: pairs must split evenly into gate groups");
   end

   for (genvar i = 0; i < NUM_PAIRS; i++) begin : g_pair
      logic [1:0] drv;
      assign drv   = pair_drive(ck, gate[i / PER_GROUP], gl, pd_n);
      assign q[i]  = drv[1];
      assign qn[i] = drv[0];
   end

endmodule

// File: rtl/clksw_mux.sv
`timescale 1ns/1ps
module clksw_mux
   import clksw_pkg::*;
#(
   parameter int NUM_PAIRS   = 16,
   parameter int SYNC_STAGES = 2
) (
   input  logic                 clk1,
   input  logic                 clk2,
   input  logic                 rst_n,
   input  logic                 sel,
   input  logic                 fsel,
   input  logic                 g1,
   input  logic                 g2,
   input  logic                 gl,
   input  logic                 pd_n,
   output logic [NUM_PAIRS-1:0] q,
   output logic [NUM_PAIRS-1:0] qn
);

   localparam int HALF = NUM_PAIRS / GATE_GROUPS;

   if (NUM_PAIRS < GATE_GROUPS || NUM_PAIRS % GATE_GROUPS != 0) begin : g_bad_pairs
      $error("clksw_mux: pair count must be a positive even number");
   end

   logic en_a;
   logic en_b;

   clksw_leg #(
      .SYNC_STAGES  (SYNC_STAGES),
      .PICK_ON_HIGH (1'b1)
   ) u_leg_a (
      .clk      (clk1),
      .rst_n    (rst_n),
      .sel      (sel),
      .fsel     (fsel),
      .other_en (en_b),
      .en       (en_a)
   );

   clksw_leg #(
      .SYNC_STAGES  (SYNC_STAGES),
      .PICK_ON_HIGH (1'b0)
   ) u_leg_b (
      .clk      (clk2),
      .rst_n    (rst_n),
      .sel      (sel),
      .fsel     (fsel),
      .other_en (en_a),
      .en       (en_b)
   );

   logic ck_mix;
   assign ck_mix = (clk1 & en_a) | (clk2 & en_b);

   clksw_fanout #(
      .NUM_PAIRS  (NUM_PAIRS),
      .NUM_GROUPS (GATE_GROUPS)
   ) u_fanout (
      .ck   (ck_mix),
      .gate ({g2, g1}),
      .gl   (gl),
      .pd_n (pd_n),
      .q    (q),
      .qn   (qn)
   );

   // R2: the two legs never pass their clocks together
   p_one_leg_a_r2: assert property (@(posedge clk1) disable iff (!rst_n)
      !(en_a && en_b));
   p_one_leg_b_r2: assert property (@(posedge clk2) disable iff (!rst_n)
      !(en_a && en_b));

   // R9: power-down pulls every output high
   p_pd_high_r9: assert property (@(posedge clk1) disable iff (!rst_n)
      !pd_n |-> (&q && &qn));

   // R7 and R8: a gated first half sits at the park level
   p_park_lo_half_r7: assert property (@(posedge clk1) disable iff (!rst_n)
      (pd_n && g1) |-> (q[0] == gl && qn[HALF-1] != gl));
   p_park_hi_half_r8: assert property (@(posedge clk1) disable iff (!rst_n)
      (pd_n && g2) |-> (q[HALF] == gl && qn[NUM_PAIRS-1] != gl));

   // R11: outside power-down every pair is complementary
   p_comp_pair_r11: assert property (@(posedge clk1) disable iff (!rst_n)
      pd_n |-> ((q ^ qn) == {NUM_PAIRS{1'b1}}));

endmodule

// File: tb/clksw_mux_tb.sv
`timescale 1ns/1ps
module clksw_mux_tb;

   localparam real T1 = 20.0;   // 50 MHz bench clock on clk1
   localparam real T2 = 34.0;   // unrelated second source

   logic        clk1 = 1'b0;
   logic        clk2 = 1'b0;
   logic        clk2_run = 1'b1;
   logic        rst_n, sel, fsel, g1, g2, gl, pd_n;
   logic [15:0] q, qn;

   int total = 0;
   int bad   = 0;

   clksw_mux u_dut (
      .clk1 (clk1), .clk2 (clk2), .rst_n (rst_n), .sel (sel), .fsel (fsel),
      .g1 (g1), .g2 (g2), .gl (gl), .pd_n (pd_n), .q (q), .qn (qn)
   );

   always #10 clk1 = ~clk1;
   initial forever begin
      #17;
      if (clk2_run) clk2 = ~clk2;
      else          clk2 = 1'b0;
   end

   // pulse monitor on pair 1
   logic    mon_on = 1'b0;
   logic    have_last = 1'b0;
   realtime last_t = 0.0;
   realtime max_low = 0.0;
   realtime gap_start = 0.0;
   int      viol = 0;

   always @(q[0]) begin
      if (mon_on) begin
         if (have_last) begin
            if ($realtime - last_t < 9.0) viol++;
            if (q[0] && ($realtime - last_t > max_low)) begin
               max_low   = $realtime - last_t;
               gap_start = last_t;
            end
         end
         last_t    = $realtime;
         have_last = 1'b1;
      end
   end

   task automatic mon_start();
      viol = 0; max_low = 0.0; have_last = 1'b0; mon_on = 1'b1;
   endtask

   task automatic chk(input bit ok, input string req, input string what,
                      input longint act, input longint exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   function automatic logic [15:0] exp_word(input logic [15:0] run_mask,
                                            input logic ckv, input logic park);
      return (run_mask & {16{ckv}}) | (~run_mask & {16{park}});
   endfunction

   // three high/low samples of the chosen clock against expected outputs
   task automatic follow(input bit on1, input logic [15:0] run_mask,
                         input string req);
      bit ok = 1'b1;
      logic [15:0] a_hi = '0, a_lo = '0;
      for (int k = 0; k < 3; k++) begin
         if (on1) @(posedge clk1); else @(posedge clk2);
         #3;
         if (q != exp_word(run_mask, 1'b1, gl) || qn != ~exp_word(run_mask, 1'b1, gl)) begin
            ok = 1'b0; a_hi = q;
         end
         if (on1) @(negedge clk1); else @(negedge clk2);
         #3;
         if (q != exp_word(run_mask, 1'b0, gl) || qn != ~exp_word(run_mask, 1'b0, gl)) begin
            ok = 1'b0; a_lo = q;
         end
      end
      chk(ok, req, "outputs track selected clock (hi/lo word)",
          {a_hi, a_lo}, {exp_word(run_mask, 1'b1, gl), exp_word(run_mask, 1'b0, gl)});
   endtask

   // normal switchover with timing audit
   task automatic switch_to(input logic new_sel);
      realtime t_sel, t_old, t_new;
      t_old = new_sel ? T2 : T1;
      t_new = new_sel ? T1 : T2;
      mon_start();
      sel   = new_sel;
      t_sel = $realtime;
      repeat (40) @(posedge clk1);
      #1 mon_on = 1'b0;
      chk(viol == 0, "R2", "short pulses around switch", viol, 0);
      chk((gap_start - t_sel >= t_old) && (gap_start - t_sel <= 3.0 * t_old),
          "R3", "old clock stop delay ns", $rtoi(gap_start - t_sel), $rtoi(2.0 * t_old));
      chk((max_low >= t_new) && (max_low <= 4.0 * t_new),
          "R4", "low gap ns", $rtoi(max_low), $rtoi(2.5 * t_new));
      follow(new_sel, 16'hFFFF, "R1");
   endtask

   // watchdog
   initial begin
      #500000;
      total++; bad++;
      $display("FAIL watchdog: actual=expired expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      void'($urandom(32'd1234));
      rst_n = 1'b0; sel = 1'b1; fsel = 1'b0; g1 = 1'b0; g2 = 1'b0;
      gl = 1'b0; pd_n = 1'b1;

      // R10: reset state and low hold after release
      #95;
      chk(q == 16'h0000 && qn == 16'hFFFF, "R10", "outputs during reset", q, 0);
      #8 rst_n = 1'b1;
      #1;
      chk(q == 16'h0000, "R10", "low right after release", q, 0);
      repeat (10) @(posedge clk1);
      follow(1'b1, 16'hFFFF, "R10");

      // R1, R2, R3, R4: directed switches both ways
      switch_to(1'b0);
      switch_to(1'b1);

      // R7, R8: gating
      @(negedge clk1); #3;
      g1 = 1'b1; gl = 1'b1;
      #1;
      chk(q[7:0] == 8'hFF && qn[7:0] == 8'h00, "R8", "g1 park high", q[7:0], 8'hFF);
      follow(1'b1, 16'hFF00, "R7");
      gl = 1'b0; g2 = 1'b1;
      #1;
      chk(q == 16'h0000 && qn == 16'hFFFF, "R8", "both halves park low", q, 0);
      g1 = 1'b0;
      follow(1'b1, 16'h00FF, "R7");
      gl = 1'b1;
      follow(1'b1, 16'h00FF, "R8");

      // R9: power-down overrides gates and clock
      @(posedge clk1); #2;
      pd_n = 1'b0;
      #1;
      chk(q == 16'hFFFF && qn == 16'hFFFF, "R9", "power-down all high (clk high)", q, 16'hFFFF);
      @(negedge clk1); #3;
      chk(q == 16'hFFFF && qn == 16'hFFFF, "R9", "power-down all high (clk low)", qn, 16'hFFFF);
      pd_n = 1'b1; g2 = 1'b0; gl = 1'b0;
      #1;
      chk((q ^ qn) == 16'hFFFF, "R11", "pairs complementary", q ^ qn, 16'hFFFF);

      // R5: force entry drops output at once, then restarts
      @(posedge clk1); #2;
      fsel = 1'b1;
      #1;
      chk(q[0] == 1'b0, "R5", "output low at force entry", q[0], 0);
      repeat (8) @(posedge clk1);
      follow(1'b1, 16'hFFFF, "R5");
      fsel = 1'b0;
      repeat (20) @(posedge clk1);

      // R5: recovery when the running clk2 freezes with its leg enabled
      switch_to(1'b0);
      @(negedge clk2); #1;
      clk2_run = 1'b0;
      #40;
      fsel = 1'b0; #2;
      sel  = 1'b1; #2;
      fsel = 1'b1;
      repeat (12) @(posedge clk1);
      follow(1'b1, 16'hFFFF, "R5");

      // R6: restarting the deselected clock under force changes nothing
      mon_start();
      clk2_run = 1'b1;
      repeat (40) @(posedge clk1);
      #1 mon_on = 1'b0;
      chk(viol == 0 && max_low <= 11.0, "R6", "clean clk1 while clk2 restarts",
          $rtoi(max_low), 10);
      follow(1'b1, 16'hFFFF, "R6");
      fsel = 1'b0;
      repeat (20) @(posedge clk1);
      follow(1'b1, 16'hFFFF, "R6");

      // random switch timing
      for (int k = 0; k < 10; k++) begin
         int hold;
         hold = 5 + int'($urandom % 30);
         repeat (hold) @(posedge clk1);
         #($urandom % 19 + 1);
         switch_to(~sel);
      end

      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule